// File: doc/BRIEF.md
# Polled Character Input/Output Register Block

This block places a character input channel and a character output channel on a 16-bit word-addressed processor bus, as four registers. Software polls a ready flag in each status word, or it sets an enable bit so that a ready flag raises an interrupt request. On the keyboard side, a strobed 8-bit code is latched and held until software reads it. Until that read, the keyboard channel accepts no further codes. On the display side, a write hands one 8-bit code to the display with a one-cycle strobe. The channel then refuses further writes until the display answers with a done pulse.

The bus reports whether an access hits one of the four registers. When it does not, the surrounding logic routes the memory data path instead. Read data comes straight from register state in the cycle of the access. All effects of an access (clearing or setting flags, latching codes) take place at the clock edge that ends the access.

Top module: `char_io_ports`

## Requirements
- R1: Accesses with `bus_sel` high to address 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status) or 0xFE06 (display data) drive `bus_hit` high. Any other address drives `bus_hit` low and `bus_rdata` to zero.
- R2: After reset, keyboard status reads 0x0000, display status reads 0x8000, both interrupt requests are low and `disp_strobe` is low.
- R3: When `key_valid` is high while keyboard status bit 15 is 0, the code on `key_char` is latched at that edge. From the next cycle, keyboard data reads {8'h00, code} and keyboard status bit 15 reads 1.
- R4: While keyboard status bit 15 is 1, codes arriving on `key_char` are discarded, and the held code is unchanged.
- R5: A read of keyboard data while bit 15 is 1 clears keyboard status bit 15 at that edge, after which a new code is accepted again.
- R6: A write to display data while display status bit 15 is 1 clears bit 15. In the next cycle it raises `disp_strobe` for exactly one cycle, with `disp_char` equal to write data bits [7:0]. Display data then reads {8'h00, that code}.
- R7: A write to display data while display status bit 15 is 0 produces no strobe and leaves the held code unchanged.
- R8: A `disp_done` pulse while display status bit 15 is 0 sets bit 15 in the following cycle.
- R9: Bit 14 of each status register is a software-writable interrupt enable. A status write changes only bit 14, and status bits 13:0 read as zero.
- R10: `irq_key` is keyboard bit 15 AND keyboard bit 14, and `irq_disp` is display bit 15 AND display bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in progress this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not hit |
| bus_hit | output | 1 | Access addresses one of the four registers |
| key_valid | input | 1 | Keyboard code strobe |
| key_char | input | 8 | Keyboard code |
| disp_char | output | 8 | Code sent to the display |
| disp_strobe | output | 1 | One-cycle send strobe |
| disp_done | input | 1 | Display finished with the last code |
| irq_key | output | 1 | Keyboard interrupt request |
| irq_disp | output | 1 | Display interrupt request |

## Verification
Every one of the 256 keyboard codes is latched, then followed by a different code that must be dropped. This separates a correct hold from a design that overwrites the held code or never clears the flag on a data read. Every one of the 256 display codes is written, then followed at once by its complement while busy, so an ignored write is told apart from a leaky one by both the strobe and the read-back value. An address sweep around the register window, including the odd addresses between registers, separates exact decoding from decoding that ignores low address bits. Enable-bit patterns of all ones and all zeros show that status writes touch only bit 14 and that each interrupt follows its own channel.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
    typedef enum logic [2:0] {
        REG_NONE  = 3'd0,
        REG_KSTAT = 3'd1,
        REG_KDATA = 3'd2,
        REG_DSTAT = 3'd3,
        REG_DDATA = 3'd4
    } cio_reg_e;
endpackage

// File: rtl/char_io_decode.sv
module char_io_decode
    import char_io_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] KSTAT_ADDR = 'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_ADDR = 'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_ADDR = 'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_ADDR = 'hFE06
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output cio_reg_e          reg_sel,
    output logic              hit
);
    always_comb begin
        reg_sel = REG_NONE;
        if (bus_sel) begin
            if (bus_addr == KSTAT_ADDR)      reg_sel = REG_KSTAT;
            else if (bus_addr == KDATA_ADDR) reg_sel = REG_KDATA;
            else if (bus_addr == DSTAT_ADDR) reg_sel = REG_DSTAT;
            else if (bus_addr == DDATA_ADDR) reg_sel = REG_DDATA;
        end
        hit = (reg_sel != REG_NONE);
    end
endmodule

// File: rtl/char_io_key_port.sv
module char_io_key_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              data_rd,
    input  logic              stat_wr,
    input  logic              ie_wdata,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] data
);
    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic [CHAR_W-1:0] data;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_wr) begin
            st_d.ie = ie_wdata;
        end
        if (st_q.rdy && data_rd) begin
            st_d.rdy = 1'b0;
        end else if (!st_q.rdy && key_valid) begin
            st_d.rdy  = 1'b1;
            st_d.data = key_char;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy  = st_q.rdy;
    assign ie   = st_q.ie;
    assign data = st_q.data;

    // R3
    key_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && key_valid) |=> (rdy && data == $past(key_char)));
    // R4
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !data_rd) |=> (rdy && $stable(data)));
    // R5
    key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && data_rd) |=> !rdy);
endmodule

// File: rtl/char_io_disp_port.sv
module char_io_disp_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              stat_wr,
    input  logic              ie_wdata,
    input  logic              done,
    output logic              rdy,
    output logic              ie,
    output logic              strobe,
    output logic [CHAR_W-1:0] out_char
);
    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic              strobe;
        logic [CHAR_W-1:0] chr;
    } disp_state_t;

    disp_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (stat_wr) begin
            st_d.ie = ie_wdata;
        end
        if (st_q.rdy && data_wr) begin
            st_d.rdy    = 1'b0;
            st_d.strobe = 1'b1;
            st_d.chr    = wchar;
        end else if (!st_q.rdy && done) begin
            st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy      = st_q.rdy;
    assign ie       = st_q.ie;
    assign strobe   = st_q.strobe;
    assign out_char = st_q.chr;

    // R6
    disp_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && data_wr) |=> (strobe && !rdy && out_char == $past(wchar)));
    // R7
    disp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> (!strobe && $stable(out_char)));
    // R8
    disp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && done) |=> rdy);
endmodule

// File: rtl/char_io_ports.sv
module char_io_ports
    import char_io_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] KSTAT_ADDR = 'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_ADDR = 'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_ADDR = 'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_ADDR = 'hFE06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    output logic [CHAR_W-1:0] disp_char,
    output logic              disp_strobe,
    input  logic              disp_done,
    output logic              irq_key,
    output logic              irq_disp
);
    localparam int RDY_BIT = DATA_W - 1;
    localparam int IE_BIT  = DATA_W - 2;
    localparam int PAD_W   = DATA_W - CHAR_W;

    cio_reg_e reg_sel;
    logic     k_rdy, k_ie, d_rdy, d_ie;
    logic [CHAR_W-1:0] k_data;
    logic     wdata_unused;

    assign wdata_unused = &{1'b0, bus_wdata[RDY_BIT], bus_wdata[IE_BIT-1:CHAR_W]};

    char_io_decode #(
        .ADDR_W(ADDR_W), .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
        .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR)
    ) u_dec (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .reg_sel (reg_sel),
        .hit     (bus_hit)
    );

    char_io_key_port #(.CHAR_W(CHAR_W)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_valid(key_valid),
        .key_char (key_char),
        .data_rd  (reg_sel == REG_KDATA && !bus_we),
        .stat_wr  (reg_sel == REG_KSTAT && bus_we),
        .ie_wdata (bus_wdata[IE_BIT]),
        .rdy      (k_rdy),
        .ie       (k_ie),
        .data     (k_data)
    );

    char_io_disp_port #(.CHAR_W(CHAR_W)) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (reg_sel == REG_DDATA && bus_we),
        .wchar   (bus_wdata[CHAR_W-1:0]),
        .stat_wr (reg_sel == REG_DSTAT && bus_we),
        .ie_wdata(bus_wdata[IE_BIT]),
        .done    (disp_done),
        .rdy     (d_rdy),
        .ie      (d_ie),
        .strobe  (disp_strobe),
        .out_char(disp_char)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel)
            REG_KSTAT: begin
                bus_rdata[RDY_BIT] = k_rdy;
                bus_rdata[IE_BIT]  = k_ie;
            end
            REG_KDATA: bus_rdata = {{PAD_W{1'b0}}, k_data};
            REG_DSTAT: begin
                bus_rdata[RDY_BIT] = d_rdy;
                bus_rdata[IE_BIT]  = d_ie;
            end
            REG_DDATA: bus_rdata = {{PAD_W{1'b0}}, disp_char};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_key  = k_rdy & k_ie;
    assign irq_disp = d_rdy & d_ie;

    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hit |-> (bus_rdata == '0));
    // R9
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == REG_KSTAT || reg_sel == REG_DSTAT) |-> (bus_rdata[IE_BIT-1:0] == '0));
    // R9
    kstat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == REG_KSTAT && bus_we) |=> (k_ie == $past(bus_wdata[IE_BIT])));
endmodule

// File: tb/char_io_ports_test.sv
`timescale 1ns/1ps
module char_io_ports_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_hit;
    logic        key_valid = 1'b0;
    logic [7:0]  key_char = '0;
    logic [7:0]  disp_char;
    logic        disp_strobe;
    logic        disp_done = 1'b0;
    logic        irq_key, irq_disp;

    int checks = 0;
    int fails  = 0;

    localparam logic [15:0] A_KS = 16'hFE00, A_KD = 16'hFE02,
                            A_DS = 16'hFE04, A_DD = 16'hFE06;

    always #10 clk = ~clk;

    char_io_ports uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_hit(bus_hit), .key_valid(key_valid), .key_char(key_char),
        .disp_char(disp_char), .disp_strobe(disp_strobe), .disp_done(disp_done),
        .irq_key(irq_key), .irq_disp(irq_disp)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d, output logic h);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; h = bus_hit;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic key(input logic [7:0] c);
        @(negedge clk);
        key_valid = 1'b1; key_char = c;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        disp_done = 1'b1;
        @(negedge clk);
        disp_done = 1'b0;
    endtask

    task automatic expect_rd(input logic [15:0] a, input logic [15:0] e, input string req);
        logic [15:0] d;
        logic h;
        rd(a, d, h);
        chk(d == e, req, d, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        #1;
        chk(irq_key == 1'b0 && irq_disp == 1'b0, "R2 irqs", {14'b0, irq_key, irq_disp}, 16'h0);
        chk(disp_strobe == 1'b0, "R2 strobe", {15'b0, disp_strobe}, 16'h0);
        expect_rd(A_KS, 16'h0000, "R2 kstat");
        expect_rd(A_DS, 16'h8000, "R2 dstat");

        // R1 address sweep around the window
        for (int a = 16'hFDF8; a <= 16'hFE0F; a++) begin
            logic exp_hit;
            exp_hit = (a == A_KS) || (a == A_KD) || (a == A_DS) || (a == A_DD);
            rd(16'(a), d, h);
            chk(h == exp_hit, "R1 hit", {15'b0, h}, {15'b0, exp_hit});
            if (!exp_hit) chk(d == 16'h0, "R1 miss data", d, 16'h0);
        end
        rd(16'h0000, d, h); chk(h == 1'b0 && d == 16'h0, "R1 low addr", d, 16'h0);
        rd(16'hFFFF, d, h); chk(h == 1'b0 && d == 16'h0, "R1 top addr", d, 16'h0);

        // R3 R4 R5 keyboard sweep over every code
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cc;
            cc = 8'(c);
            key(cc);
            expect_rd(A_KS, 16'h8000, "R3 kstat set");
            key(cc ^ 8'hA5);
            expect_rd(A_KD, {8'h00, cc}, "R4 held code");
            expect_rd(A_KS, 16'h0000, "R5 kstat cleared");
        end

        // R6 R7 R8 display sweep over every code
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cc;
            cc = 8'(c);
            wr(A_DD, {8'hC3, cc});
            chk(disp_strobe == 1'b1 && disp_char == cc, "R6 strobe",
                {7'b0, disp_strobe, disp_char}, {8'h01, cc});
            @(negedge clk);
            chk(disp_strobe == 1'b0, "R6 one cycle", {15'b0, disp_strobe}, 16'h0);
            expect_rd(A_DS, 16'h0000, "R6 dstat cleared");
            wr(A_DD, {8'h00, ~cc});
            chk(disp_strobe == 1'b0, "R7 no strobe", {15'b0, disp_strobe}, 16'h0);
            expect_rd(A_DD, {8'h00, cc}, "R7 code kept");
            done_pulse();
            expect_rd(A_DS, 16'h8000, "R8 dstat set");
        end

        // R9 R10 enable bits
        wr(A_KS, 16'hFFFF);
        expect_rd(A_KS, 16'h4000, "R9 kstat ie only");
        chk(irq_key == 1'b0, "R10 irq_key idle", {15'b0, irq_key}, 16'h0);
        key(8'h5A);
        #1;
        chk(irq_key == 1'b1, "R10 irq_key ready", {15'b0, irq_key}, 16'h1);
        chk(irq_disp == 1'b0, "R10 irq_disp off", {15'b0, irq_disp}, 16'h0);
        wr(A_KS, 16'h0000);
        expect_rd(A_KS, 16'h8000, "R9 kstat keeps ready");
        chk(irq_key == 1'b0, "R10 irq_key disabled", {15'b0, irq_key}, 16'h0);
        expect_rd(A_KD, 16'h005A, "R9 data unchanged");
        wr(A_DS, 16'h4000);
        expect_rd(A_DS, 16'hC000, "R9 dstat ie set");
        chk(irq_disp == 1'b1, "R10 irq_disp ready", {15'b0, irq_disp}, 16'h1);
        wr(A_DD, 16'h0041);
        chk(irq_disp == 1'b0, "R10 irq_disp busy", {15'b0, irq_disp}, 16'h0);
        done_pulse();
        #1;
        chk(irq_disp == 1'b1, "R10 irq_disp done", {15'b0, irq_disp}, 16'h1);
        wr(A_DS, 16'hBFFF);
        expect_rd(A_DS, 16'h8000, "R9 dstat ie cleared");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule